// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers a bank of interrupt request lines and decides which one the processor should service next. Every source has its own enable bit and a three-bit priority; a priority of zero keeps the source out of arbitration. A pending, enabled source competes only when its priority is strictly above the processor's current running priority. The highest priority wins, and among equal priorities the lowest source index wins.

On acceptance the controller pulses a one-hot acknowledge back to the winning source and latches the source index and its vector address. The address comes from one of two tables of equal size, chosen by a table-select input sampled at acceptance: the primary table starts at byte address 0x000004, the alternate table at 0x000084, and each vector takes two byte addresses (one program word). A fixed number of cycles after acceptance, the same for every source, a one-cycle entry strobe tells the processor to branch to the latched vector. No further request is accepted while one is in flight.

A small stack-bound guard sits beside the arbiter: a push to an address above a limit or a pop from an address below a base raises a one-cycle trap flag.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, `ack_o`, `entry_o`, `vec_addr_o`, `src_id_o` and `trap_o` are all zero.
- R2: Source i takes part only when `irq_req_i[i]` and `irq_en_i[i]` are high and its priority field `irq_prio_i[3*i+2:3*i]` is non-zero; otherwise it is never acknowledged.
- R3: A source is accepted only when its priority is strictly greater than `cpu_prio_i`; at equal or lower priority it is not acknowledged.
- R4: Among eligible sources the highest priority wins; at equal priority the lowest index wins.
- R5: `ack_o` is one-hot with bit i set for exactly one cycle, the cycle after the clock edge at which source i is accepted; it is zero otherwise.
- R6: `entry_o` is high for exactly one cycle, five clock edges after the edge at which `ack_o` rose, for every source.
- R7: `src_id_o` takes the winner's index and `vec_addr_o` takes 0x000004 + 2*i when `alt_tbl_i` is low at acceptance, or 0x000084 + 2*i when high; both stay unchanged until the next acceptance, whatever `alt_tbl_i` does meanwhile.
- R8: From acceptance until the entry strobe no other request is accepted, even one of higher priority; the earliest next acceptance is the edge at which `entry_o` is high, so the next `ack_o` appears the cycle after the strobe.
- R9: `trap_o` is high in the cycle after an edge at which `sp_push_i` was high with `sp_addr_i` > `sp_limit_i`, or `sp_pop_i` was high with `sp_addr_i` < `sp_base_i`; an access exactly at the limit or base raises no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req_i | input | 45 | Request line per source, level |
| irq_en_i | input | 45 | Enable bit per source |
| irq_prio_i | input | 135 | Three-bit priority per source, source i at bits 3*i+2..3*i |
| cpu_prio_i | input | 3 | Current running priority of the processor |
| alt_tbl_i | input | 1 | Selects the alternate vector table when high |
| sp_push_i | input | 1 | Stack push in this cycle |
| sp_pop_i | input | 1 | Stack pop in this cycle |
| sp_addr_i | input | 16 | Address of the stack access |
| sp_limit_i | input | 16 | Highest legal push address |
| sp_base_i | input | 16 | Lowest legal pop address |
| ack_o | output | 45 | One-hot acknowledge to the accepted source |
| entry_o | output | 1 | Service-entry strobe |
| vec_addr_o | output | 24 | Vector address of the accepted source |
| src_id_o | output | 6 | Index of the accepted source |
| trap_o | output | 1 | Stack-bound violation flag |

## Verification
The assertions take for granted that a source drops its request once acknowledged and that the priority, enable and running-priority inputs are settled at each clock edge, since the priority check compares the acknowledged source against the values sampled at the acceptance edge. The stimulus drives every input away from the active edge, clears the served request in the cycle the acknowledge is seen, and raises new requests during a service only to show they wait. Stack accesses are applied for a single cycle each, with push and pop never together.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int unsigned NUM_SRC   = 45;
    localparam int unsigned PRIO_W    = 3;
    localparam int unsigned ENTRY_LAT = 5;
    localparam int unsigned VEC_W     = 24;
    localparam int unsigned SP_W      = 16;
    localparam logic [VEC_W-1:0] PRI_BASE = 24'h000004;
    localparam logic [VEC_W-1:0] ALT_BASE = 24'h000084;
endpackage

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
    parameter int unsigned NSRC = 45,
    parameter int unsigned PW   = 3,
    localparam int unsigned IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]    req_i,
    input  logic [NSRC-1:0]    en_i,
    input  logic [NSRC*PW-1:0] prio_i,
    input  logic [PW-1:0]      cpu_prio_i,
    output logic               valid_o,
    output logic [IDW-1:0]     win_id_o
);
    logic [PW-1:0] best_prio;

    // Ascending scan with strict compare: lowest index keeps a tie.
    always_comb begin
        valid_o   = 1'b0;
        win_id_o  = '0;
        best_prio = cpu_prio_i;
        for (int i = 0; i < NSRC; i++) begin
            if (req_i[i] && en_i[i] && (prio_i[i*PW +: PW] != '0) &&
                (prio_i[i*PW +: PW] > best_prio)) begin
                valid_o   = 1'b1;
                win_id_o  = IDW'(i);
                best_prio = prio_i[i*PW +: PW];
            end
        end
    end
endmodule

// File: rtl/intc_stack_guard.sv
module intc_stack_guard #(
    parameter int unsigned SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [SW-1:0] addr_i,
    input  logic [SW-1:0] limit_i,
    input  logic [SW-1:0] base_i,
    output logic          trap_o
);
    logic trap_d, trap_q;

    always_comb begin
        trap_d = (push_i && (addr_i > limit_i)) || (pop_i && (addr_i < base_i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trap_q <= 1'b0;
        else        trap_q <= trap_d;
    end

    assign trap_o = trap_q;
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
    import intc_pkg::*;
#(
    parameter int unsigned NSRC = NUM_SRC,
    parameter int unsigned PW   = PRIO_W,
    parameter int unsigned LAT  = ENTRY_LAT,
    parameter int unsigned AW   = VEC_W,
    parameter int unsigned SW   = SP_W,
    parameter logic [AW-1:0] PRI_VEC_BASE = PRI_BASE,
    parameter logic [AW-1:0] ALT_VEC_BASE = ALT_BASE,
    localparam int unsigned IDW = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int unsigned CW  = (LAT > 1) ? $clog2(LAT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSRC-1:0]    irq_req_i,
    input  logic [NSRC-1:0]    irq_en_i,
    input  logic [NSRC*PW-1:0] irq_prio_i,
    input  logic [PW-1:0]      cpu_prio_i,
    input  logic               alt_tbl_i,
    input  logic               sp_push_i,
    input  logic               sp_pop_i,
    input  logic [SW-1:0]      sp_addr_i,
    input  logic [SW-1:0]      sp_limit_i,
    input  logic [SW-1:0]      sp_base_i,
    output logic [NSRC-1:0]    ack_o,
    output logic               entry_o,
    output logic [AW-1:0]      vec_addr_o,
    output logic [IDW-1:0]     src_id_o,
    output logic               trap_o
);
    typedef struct packed {
        logic            busy;
        logic [CW-1:0]   cnt;
        logic            entry;
        logic [NSRC-1:0] ack;
        logic [AW-1:0]   vec;
        logic [IDW-1:0]  id;
    } state_t;

    state_t st_d, st_q;
    logic           win_valid;
    logic [IDW-1:0] win_id;

    intc_arbiter #(.NSRC(NSRC), .PW(PW)) arb_i (
        .req_i      (irq_req_i),
        .en_i       (irq_en_i),
        .prio_i     (irq_prio_i),
        .cpu_prio_i (cpu_prio_i),
        .valid_o    (win_valid),
        .win_id_o   (win_id)
    );

    intc_stack_guard #(.SW(SW)) guard_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (sp_push_i),
        .pop_i   (sp_pop_i),
        .addr_i  (sp_addr_i),
        .limit_i (sp_limit_i),
        .base_i  (sp_base_i),
        .trap_o  (trap_o)
    );

    always_comb begin
        st_d       = st_q;
        st_d.entry = 1'b0;
        st_d.ack   = '0;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy  = 1'b0;
                st_d.entry = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (win_valid) begin
            st_d.busy        = 1'b1;
            st_d.cnt         = CW'(LAT - 1);
            st_d.ack[win_id] = 1'b1;
            st_d.id          = win_id;
            st_d.vec         = (alt_tbl_i ? ALT_VEC_BASE : PRI_VEC_BASE) +
                               (AW'(win_id) << 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack_o      = st_q.ack;
    assign entry_o    = st_q.entry;
    assign vec_addr_o = st_q.vec;
    assign src_id_o   = st_q.id;
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
    parameter int unsigned NSRC = 45,
    parameter int unsigned PW   = 3,
    parameter int unsigned LAT  = 5,
    parameter int unsigned AW   = 24,
    parameter int unsigned SW   = 16,
    localparam int unsigned IDW = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int unsigned KW  = $clog2(LAT + 2)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NSRC-1:0]    irq_en_i,
    input logic [NSRC*PW-1:0] irq_prio_i,
    input logic [PW-1:0]      cpu_prio_i,
    input logic               sp_push_i,
    input logic               sp_pop_i,
    input logic [SW-1:0]      sp_addr_i,
    input logic [SW-1:0]      sp_limit_i,
    input logic [SW-1:0]      sp_base_i,
    input logic [NSRC-1:0]    ack_o,
    input logic               entry_o,
    input logic [AW-1:0]      vec_addr_o,
    input logic [IDW-1:0]     src_id_o,
    input logic               trap_o
);
    logic [KW-1:0]      since_ack;
    logic [NSRC*PW-1:0] prio_q;
    logic [NSRC-1:0]    en_q;
    logic [PW-1:0]      cpu_q;
    logic               viol_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_ack <= '0;
            prio_q    <= '0;
            en_q      <= '0;
            cpu_q     <= '0;
            viol_q    <= 1'b0;
        end else begin
            prio_q <= irq_prio_i;
            en_q   <= irq_en_i;
            cpu_q  <= cpu_prio_i;
            viol_q <= (sp_push_i && (sp_addr_i > sp_limit_i)) ||
                      (sp_pop_i && (sp_addr_i < sp_base_i));
            if (|ack_o)                       since_ack <= KW'(1);
            else if (since_ack == KW'(LAT))   since_ack <= '0;
            else if (since_ack != '0)         since_ack <= since_ack + 1'b1;
        end
    end

    a_r5_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_o));
    a_r5_ack_matches_id: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_o) |-> ack_o[src_id_o]);
    a_r2_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_o) |-> (en_q[src_id_o] && (prio_q[src_id_o*PW +: PW] != '0)));
    a_r3_above_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_o) |-> (prio_q[src_id_o*PW +: PW] > cpu_q));
    a_r6_entry_on_time: assert property (@(posedge clk) disable iff (!rst_n)
        (since_ack == KW'(LAT)) |-> entry_o);
    a_r6_entry_only_then: assert property (@(posedge clk) disable iff (!rst_n)
        entry_o |-> (since_ack == KW'(LAT)));
    a_r7_vec_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_ack != '0) && !(|ack_o)) |-> ($stable(vec_addr_o) && $stable(src_id_o)));
    a_r8_no_accept_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        (since_ack != '0) |-> (ack_o == '0));
    a_r9_trap_match: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o == viol_q);
endmodule

bind prio_vec_intc intc_checker #(
    .NSRC(NSRC), .PW(PW), .LAT(LAT), .AW(AW), .SW(SW)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_en_i   (irq_en_i),
    .irq_prio_i (irq_prio_i),
    .cpu_prio_i (cpu_prio_i),
    .sp_push_i  (sp_push_i),
    .sp_pop_i   (sp_pop_i),
    .sp_addr_i  (sp_addr_i),
    .sp_limit_i (sp_limit_i),
    .sp_base_i  (sp_base_i),
    .ack_o      (ack_o),
    .entry_o    (entry_o),
    .vec_addr_o (vec_addr_o),
    .src_id_o   (src_id_o),
    .trap_o     (trap_o)
);

// File: tb/prio_vec_intc_tb_top.sv
module prio_vec_intc_tb_top;
    localparam int NS = 45;
    localparam int PWB = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS-1:0]   req = '0;
    logic [NS-1:0]   en = '0;
    logic [NS*3-1:0] prio = '0;
    logic [2:0]      cpu = '0;
    logic            alt = 1'b0;
    logic            push = 1'b0, pop = 1'b0;
    logic [15:0]     addr = '0, limit = 16'h0900, base = 16'h0800;
    logic [NS-1:0]   ack;
    logic            entry;
    logic [23:0]     vec;
    logic [5:0]      sid;
    logic            trap;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    prio_vec_intc dut_i (
        .clk(clk), .rst_n(rst_n), .irq_req_i(req), .irq_en_i(en),
        .irq_prio_i(prio), .cpu_prio_i(cpu), .alt_tbl_i(alt),
        .sp_push_i(push), .sp_pop_i(pop), .sp_addr_i(addr),
        .sp_limit_i(limit), .sp_base_i(base), .ack_o(ack), .entry_o(entry),
        .vec_addr_o(vec), .src_id_o(sid), .trap_o(trap)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_src(input int idx, input int p, input bit e, input bit r);
        prio[idx*PWB +: PWB] = p[2:0];
        en[idx]  = e;
        req[idx] = r;
    endtask

    // Called just after a negedge where new requests were driven.
    task automatic expect_take(input int idx, input bit use_alt, input bit disturb);
        logic [23:0] exp_vec;
        logic [NS-1:0] exp_ack;
        exp_vec = (use_alt ? 24'h000084 : 24'h000004) + 24'(idx * 2);
        exp_ack = '0;
        exp_ack[idx] = 1'b1;
        @(negedge clk);
        chk(ack == exp_ack, "R4/R5 ack", ack, exp_ack);
        chk(sid == 6'(idx), "R7 src id", sid, idx);
        chk(vec == exp_vec, "R7 vector", vec, exp_vec);
        req[idx] = 1'b0;
        for (int i = 1; i <= 5; i++) begin
            @(negedge clk);
            if (i == 1 && disturb) begin
                alt = ~alt;
                set_src(40, 7, 1'b1, 1'b1);
            end
            chk(entry == (i == 5), "R6 entry timing", entry, (i == 5));
            chk(ack == '0, "R8 no ack in flight", ack, 0);
        end
        chk(vec == exp_vec, "R7 vector held", vec, exp_vec);
    endtask

    task automatic expect_none(input string tag);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(ack == '0, tag, ack, 0);
        end
    endtask

    task automatic t_reset;
        chk(ack == '0 && entry == 1'b0 && vec == '0 && sid == '0 && trap == 1'b0,
            "R1 reset state", {ack, entry, vec, trap}, 0);
    endtask

    task automatic t_single_and_busy;
        // R6/R8: src 40 at priority 7 appears mid-flight and must wait.
        set_src(5, 3, 1'b1, 1'b1);
        expect_take(5, 1'b0, 1'b1);
        expect_take(40, 1'b1, 1'b0);
        alt = 1'b0;
    endtask

    task automatic t_priority;
        set_src(2, 2, 1'b1, 1'b1);
        set_src(30, 6, 1'b1, 1'b1);
        expect_take(30, 1'b0, 1'b0);   // R4 higher priority first
        expect_take(2, 1'b0, 1'b0);    // R8 next one right after entry
    endtask

    task automatic t_tie;
        set_src(10, 4, 1'b1, 1'b1);
        set_src(7, 4, 1'b1, 1'b1);
        expect_take(7, 1'b0, 1'b0);    // R4 lowest index on tie
        expect_take(10, 1'b0, 1'b0);
    endtask

    task automatic t_cpu_mask;
        cpu = 3'd3;
        set_src(12, 3, 1'b1, 1'b1);
        expect_none("R3 equal priority masked");
        cpu = 3'd2;
        expect_take(12, 1'b0, 1'b0);   // R3 strictly above
        cpu = 3'd0;
    endtask

    task automatic t_disabled;
        set_src(20, 5, 1'b0, 1'b1);
        expect_none("R2 disabled source");
        set_src(20, 0, 1'b1, 1'b1);
        expect_none("R2 priority zero source");
        set_src(20, 0, 1'b0, 1'b0);
    endtask

    task automatic t_alt_table;
        alt = 1'b1;
        set_src(44, 1, 1'b1, 1'b1);
        expect_take(44, 1'b1, 1'b0);   // R7 alternate table
        alt = 1'b0;
        set_src(0, 1, 1'b1, 1'b1);
        expect_take(0, 1'b0, 1'b0);    // R7 primary table, first slot
    endtask

    task automatic stack_op(input bit is_push, input logic [15:0] a, input bit exp_trap);
        push = is_push;
        pop  = ~is_push;
        addr = a;
        @(negedge clk);
        push = 1'b0;
        pop  = 1'b0;
        chk(trap == exp_trap, "R9 stack trap", trap, exp_trap);
        @(negedge clk);
        chk(trap == 1'b0, "R9 trap clears", trap, 0);
    endtask

    task automatic t_stack;
        stack_op(1'b1, 16'h0902, 1'b1);
        stack_op(1'b1, 16'h0900, 1'b0);
        stack_op(1'b0, 16'h07FE, 1'b1);
        stack_op(1'b0, 16'h0800, 1'b0);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_and_busy();
        t_priority();
        t_tie();
        t_cpu_mask();
        t_disabled();
        t_alt_table();
        t_stack();
        finish_run();
    end
endmodule